// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block sits behind the write qualifier of a parallel flash device. Each accepted write strobe, with its word address and data byte, is checked against the multi-cycle command protocol. The block keeps track of the operating mode: read-array, identification, program busy, erase busy, erase suspended, program during suspend, and error. It issues one-cycle start pulses to the external program and erase engines. The engines report back on plain done and fail inputs.

The block keeps a mask of the sectors that are being erased. This mask drives a read-source select, which tells the read path whether a read returns array contents or status. While an erase is suspended, reads to sectors in the mask return status and reads to all other sectors return array data. Write strobes are single-cycle control pulses with no back-pressure: a write is taken in every cycle where `wr_valid` is high. The read-source select is a combinational function of `rd_addr` and the stored state.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset, `mode` is 0 (read-array), both start pulses are low, `erase_mask` is zero and `rd_status_sel` is 0. The mode codes are: 0 read-array, 1 identification, 2 program busy, 3 erase busy, 4 erase suspended, 5 program during suspend, 6 error.
- R2: The four writes AAh@555h, 55h@2AAh, A0h@555h and then any address/data pulse `prog_start` high for exactly one cycle, in the cycle after the last write. In that same cycle `mode` becomes 2. Unlock addresses compare only the low 11 address bits.
- R3: Any write whose address or data does not fit the next expected cycle abandons the sequence. The mode stays read-array, and the cycles written after it start nothing.
- R4: In read-array mode, data F0h at any address cancels any partial sequence. This includes a write between erase cycles.
- R5: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h pulse `erase_start` one cycle later. The mode becomes 3 and every bit of `erase_mask` is set.
- R6: The same sequence ending in 30h at any address starts a sector erase. Only the mask bit selected by the top log2(NSECT) address bits of that write is set.
- R7: `algo_done` in mode 2 or 3 returns the mode to 0. A completed erase clears `erase_mask`.
- R8: `algo_fail` in modes 2, 3 or 5 enters mode 6. Only an F0h write leaves mode 6, and it returns to mode 0 with the mask cleared. All other writes are ignored.
- R9: Unlock followed by 90h@555h enters mode 1. Only an F0h write leaves mode 1.
- R10: In mode 3, B0h at any address enters mode 4, and every other write is ignored. In mode 4, 30h written outside a program sequence resumes mode 3, and F0h is ignored.
- R11: `rd_status_sel` is 1 in modes 2, 3, 5 and 6. It is 0 in modes 0 and 1. In mode 4 it equals the mask bit of the sector selected by `rd_addr`'s top bits.
- R12: A program sequence written in mode 4 pulses `prog_start` and enters mode 5. `algo_done` then returns to mode 4 with the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Qualified write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 8 | Data byte of the write |
| rd_addr | input | ADDR_W | Address of the current read |
| algo_done | input | 1 | Embedded program/erase finished |
| algo_fail | input | 1 | Embedded program/erase timed out |
| mode | output | 3 | Current operating mode code |
| prog_start | output | 1 | One-cycle program start pulse |
| erase_start | output | 1 | One-cycle erase start pulse |
| erase_mask | output | NSECT | Sectors selected for the current erase |
| rd_status_sel | output | 1 | 1 selects status data, 0 selects array data |

## Verification
The bench builds the block with ADDR_W=12 and NSECT=8. With these values the unlock addresses fit within the low 11 bits, and the top three address bits select one of eight sectors. Every sector index can then be reached by a randomly chosen sector erase. Random read addresses during suspend land both inside and outside the erased sector. Random corruption points across the unlock cycles, together with random offsets inside each sector, exercise the abort and address-decode paths.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    M_READ      = 3'd0,
    M_AUTOSEL   = 3'd1,
    M_PROG      = 3'd2,
    M_ERASE     = 3'd3,
    M_SUSP      = 3'd4,
    M_SUSP_PROG = 3'd5,
    M_ERROR     = 3'd6
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_U1, ST_U2, ST_PGM, ST_E1, ST_E2, ST_E3
  } step_e;

  localparam int UNLK_W = 11;
  localparam logic [UNLK_W-1:0] A_KEY1 = 11'h555;
  localparam logic [UNLK_W-1:0] A_KEY2 = 11'h2AA;
  localparam logic [7:0] D_KEY1    = 8'hAA;
  localparam logic [7:0] D_KEY2    = 8'h55;
  localparam logic [7:0] C_PROGRAM = 8'hA0;
  localparam logic [7:0] C_ERSETUP = 8'h80;
  localparam logic [7:0] C_IDENT   = 8'h90;
  localparam logic [7:0] C_RESET   = 8'hF0;
  localparam logic [7:0] C_CHIP    = 8'h10;
  localparam logic [7:0] C_SECTOR  = 8'h30;
  localparam logic [7:0] C_SUSPEND = 8'hB0;
  localparam logic [7:0] C_RESUME  = 8'h30;
endpackage

// File: rtl/fcs_seq_decode.sv
module fcs_seq_decode
  import flash_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [UNLK_W-1:0] wr_addr_lo,
  input  logic [7:0]        wr_data,
  input  mode_e             mode,
  output logic              ev_reset,
  output logic              ev_ident,
  output logic              ev_prog,
  output logic              ev_chip,
  output logic              ev_sector,
  output logic              ev_suspend,
  output logic              ev_resume
);
  step_e step_q, step_d;
  logic  at_k1, at_k2, in_read, seq_en;

  assign at_k1   = (wr_addr_lo == A_KEY1);
  assign at_k2   = (wr_addr_lo == A_KEY2);
  assign in_read = (mode == M_READ);
  assign seq_en  = (mode == M_READ) || (mode == M_SUSP);

  always_comb begin
    step_d     = step_q;
    ev_reset   = 1'b0;
    ev_ident   = 1'b0;
    ev_prog    = 1'b0;
    ev_chip    = 1'b0;
    ev_sector  = 1'b0;
    ev_suspend = 1'b0;
    ev_resume  = 1'b0;
    if (wr_valid) begin
      unique case (mode)
        M_AUTOSEL, M_ERROR: ev_reset = (wr_data == C_RESET);
        M_ERASE:            ev_suspend = (wr_data == C_SUSPEND);
        M_READ, M_SUSP: begin
          step_d = ST_IDLE;
          if (step_q == ST_PGM) ev_prog = 1'b1;
          else if (in_read && wr_data == C_RESET) ev_reset = 1'b1;
          else begin
            unique case (step_q)
              ST_IDLE: begin
                if (at_k1 && wr_data == D_KEY1) step_d = ST_U1;
                else if (!in_read && wr_data == C_RESUME) ev_resume = 1'b1;
              end
              ST_U1: if (at_k2 && wr_data == D_KEY2) step_d = ST_U2;
              ST_U2: if (at_k1) begin
                if (wr_data == C_PROGRAM) step_d = ST_PGM;
                else if (in_read && wr_data == C_ERSETUP) step_d = ST_E1;
                else if (in_read && wr_data == C_IDENT) ev_ident = 1'b1;
              end
              ST_E1: if (at_k1 && wr_data == D_KEY1) step_d = ST_E2;
              ST_E2: if (at_k2 && wr_data == D_KEY2) step_d = ST_E3;
              ST_E3: begin
                if (at_k1 && wr_data == C_CHIP) ev_chip = 1'b1;
                else if (wr_data == C_SECTOR) ev_sector = 1'b1;
              end
              default: ;
            endcase
          end
        end
        default: ;
      endcase
    end
    if (!seq_en) step_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) step_q <= ST_IDLE;
    else        step_q <= step_d;
  end

  // R3: at most one command event per write
  p_one_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_reset, ev_ident, ev_prog, ev_chip, ev_sector, ev_suspend, ev_resume}));

  // R5: erase sequences only complete from read-array
  p_erase_from_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_chip || ev_sector) |-> (mode == M_READ));
endmodule

// File: rtl/fcs_sector_mask.sv
module fcs_sector_mask
  import flash_cmd_pkg::*;
#(
  parameter int NSECT  = 8,
  localparam int SECT_W = $clog2(NSECT)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_chip,
  input  logic              set_sector,
  input  logic              clear,
  input  logic [SECT_W-1:0] wr_sect,
  input  logic [SECT_W-1:0] rd_sect,
  input  mode_e             mode,
  output logic [NSECT-1:0]  mask,
  output logic              rd_status_sel
);
  for (genvar g = 0; g < NSECT; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n || clear)                                   mask[g] <= 1'b0;
      else if (set_chip)                                     mask[g] <= 1'b1;
      else if (set_sector && wr_sect == SECT_W'(g))          mask[g] <= 1'b1;
    end
  end

  always_comb begin
    unique case (mode)
      M_PROG, M_ERASE, M_SUSP_PROG, M_ERROR: rd_status_sel = 1'b1;
      M_SUSP:                                rd_status_sel = mask[rd_sect];
      default:                               rd_status_sel = 1'b0;
    endcase
  end

  // R7: no sector stays marked in read-array
  p_mask_clear_in_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_READ) |-> (mask == '0));

  // R6: a single sector erase marks exactly one sector
  p_sector_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_sector && mask == '0) |=> ($countones(mask) == 1));
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NSECT  = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              algo_done,
  input  logic              algo_fail,
  output logic [2:0]        mode,
  output logic              prog_start,
  output logic              erase_start,
  output logic [NSECT-1:0]  erase_mask,
  output logic              rd_status_sel
);
  localparam int SECT_W = $clog2(NSECT);

  mode_e mode_q, mode_d;
  logic ev_reset, ev_ident, ev_prog, ev_chip, ev_sector, ev_suspend, ev_resume;
  logic clr_mask;

  fcs_seq_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_addr_lo (wr_addr[UNLK_W-1:0]),
    .wr_data    (wr_data),
    .mode       (mode_q),
    .ev_reset   (ev_reset),
    .ev_ident   (ev_ident),
    .ev_prog    (ev_prog),
    .ev_chip    (ev_chip),
    .ev_sector  (ev_sector),
    .ev_suspend (ev_suspend),
    .ev_resume  (ev_resume)
  );

  assign clr_mask = (mode_q == M_ERASE && algo_done && !algo_fail) ||
                    (mode_q == M_ERROR && ev_reset);

  fcs_sector_mask #(.NSECT(NSECT)) u_mask (
    .clk           (clk),
    .rst_n         (rst_n),
    .set_chip      (ev_chip),
    .set_sector    (ev_sector),
    .clear         (clr_mask),
    .wr_sect       (wr_addr[ADDR_W-1 -: SECT_W]),
    .rd_sect       (rd_addr[ADDR_W-1 -: SECT_W]),
    .mode          (mode_q),
    .mask          (erase_mask),
    .rd_status_sel (rd_status_sel)
  );

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      M_READ: begin
        if (ev_ident)                  mode_d = M_AUTOSEL;
        else if (ev_prog)              mode_d = M_PROG;
        else if (ev_chip || ev_sector) mode_d = M_ERASE;
      end
      M_AUTOSEL, M_ERROR: if (ev_reset) mode_d = M_READ;
      M_PROG: begin
        if (algo_fail)      mode_d = M_ERROR;
        else if (algo_done) mode_d = M_READ;
      end
      M_ERASE: begin
        if (algo_fail)       mode_d = M_ERROR;
        else if (algo_done)  mode_d = M_READ;
        else if (ev_suspend) mode_d = M_SUSP;
      end
      M_SUSP: begin
        if (ev_resume)    mode_d = M_ERASE;
        else if (ev_prog) mode_d = M_SUSP_PROG;
      end
      M_SUSP_PROG: begin
        if (algo_fail)      mode_d = M_ERROR;
        else if (algo_done) mode_d = M_SUSP;
      end
      default: mode_d = M_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= M_READ;
      prog_start  <= 1'b0;
      erase_start <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      prog_start  <= ev_prog;
      erase_start <= ev_chip | ev_sector;
    end
  end

  assign mode = mode_q;

  // R2: start pulses never coincide and land in a busy mode
  p_start_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_start && erase_start));
  p_prog_start_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> (mode == 3'd2 || mode == 3'd5));

  // R8: error persists until a reset command
  p_error_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd6 && !(wr_valid && wr_data == C_RESET)) |=> (mode == 3'd6));

  // R9: identification persists until a reset command
  p_ident_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && !(wr_valid && wr_data == C_RESET)) |=> (mode == 3'd1));

  // R7: a clean completion of a program returns to read-array
  p_prog_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && algo_done && !algo_fail) |=> (mode == 3'd0));

  // R10: suspend command during erase enters suspend
  p_suspend_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && wr_valid && wr_data == C_SUSPEND && !algo_done && !algo_fail)
      |=> (mode == 3'd4));
endmodule

// File: tb/tb_flash_cmd_fsm.sv
`timescale 1ns/1ps
module tb_flash_cmd_fsm;
  localparam int AW = 12;
  localparam int NS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic algo_done = 1'b0;
  logic algo_fail = 1'b0;
  logic [2:0] mode;
  logic prog_start, erase_start, rd_status_sel;
  logic [NS-1:0] erase_mask;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  flash_cmd_fsm #(.ADDR_W(AW), .NSECT(NS)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .algo_done(algo_done),
    .algo_fail(algo_fail), .mode(mode), .prog_start(prog_start),
    .erase_start(erase_start), .erase_mask(erase_mask),
    .rd_status_sel(rd_status_sel)
  );

  function automatic logic [AW-1:0] sect_addr(input int s, input int off);
    return AW'((s << 9) | (off & 9'h1FF));
  endfunction

  function automatic logic exp_sel(input logic [NS-1:0] m, input logic [AW-1:0] a);
    return m[a[AW-1 -: 3]];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic unlock();
    wr(12'h555, 8'hAA);
    wr(12'h2AA, 8'h55);
  endtask

  task automatic done_pulse(input bit fail);
    @(negedge clk);
    if (fail) algo_fail = 1'b1; else algo_done = 1'b1;
    @(negedge clk);
    algo_fail = 1'b0; algo_done = 1'b0;
  endtask

  task automatic erase_seq(input logic [AW-1:0] a, input logic [7:0] last);
    unlock();
    wr(12'h555, 8'h80);
    unlock();
    wr(a, last);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(mode == 0, "R1 mode", mode, 0);
    chk(!prog_start && !erase_start, "R1 starts", {prog_start, erase_start}, 0);
    chk(erase_mask == 0, "R1 mask", erase_mask, 0);
    chk(rd_status_sel == 0, "R1 status", rd_status_sel, 0);

    // R2 program
    unlock(); wr(12'h555, 8'hA0); wr(12'h123, 8'h5A);
    chk(prog_start == 1, "R2 pulse", prog_start, 1);
    chk(mode == 2, "R2 mode", mode, 2);
    chk(rd_status_sel == 1, "R11 busy status", rd_status_sel, 1);
    @(negedge clk);
    chk(prog_start == 0, "R2 pulse width", prog_start, 0);
    done_pulse(1'b0);
    chk(mode == 0, "R7 prog done", mode, 0);

    // R3 corruption at a random cycle of the program sequence
    for (int i = 0; i < 6; i++) begin
      int k = int'($urandom_range(0, 2));
      logic [AW-1:0] aa [3];
      logic [7:0] dd [3];
      aa[0] = 12'h555; dd[0] = 8'hAA;
      aa[1] = 12'h2AA; dd[1] = 8'h55;
      aa[2] = 12'h555; dd[2] = 8'hA0;
      if ($urandom_range(0, 1) == 1) dd[k] = dd[k] ^ 8'h01;
      else aa[k] = aa[k] ^ 12'h004;
      for (int j = 0; j < 3; j++) wr(aa[j], dd[j]);
      wr(12'h321, 8'h12);
      chk(prog_start == 0, "R3 no start", prog_start, 0);
      chk(mode == 0, "R3 mode", mode, 0);
    end

    // R9 identification
    unlock(); wr(12'h555, 8'h90);
    chk(mode == 1, "R9 enter", mode, 1);
    chk(rd_status_sel == 0, "R11 ident status", rd_status_sel, 0);
    unlock(); wr(12'h555, 8'hA0); wr(12'h010, 8'h00);
    chk(mode == 1 && prog_start == 0, "R9 ignore", mode, 1);
    wr(AW'($urandom), 8'hF0);
    chk(mode == 0, "R9 exit", mode, 0);

    // R4 reset between erase cycles
    unlock(); wr(12'h555, 8'h80); wr(12'h555, 8'hAA);
    wr(AW'($urandom), 8'hF0);
    wr(12'h2AA, 8'h55); wr(sect_addr(3, 0), 8'h30);
    chk(erase_start == 0, "R4 cancel", erase_start, 0);
    chk(mode == 0, "R4 mode", mode, 0);

    // R5 chip erase
    erase_seq(12'h555, 8'h10);
    chk(erase_start == 1, "R5 pulse", erase_start, 1);
    chk(mode == 3, "R5 mode", mode, 3);
    chk(erase_mask == {NS{1'b1}}, "R5 mask", erase_mask, 8'hFF);
    wr(12'h555, 8'hF0); unlock(); wr(12'h555, 8'hA0); wr(12'h555, 8'h30);
    chk(mode == 3 && prog_start == 0, "R10 ignore in erase", mode, 3);
    done_pulse(1'b0);
    chk(mode == 0, "R7 erase done", mode, 0);
    chk(erase_mask == 0, "R7 mask cleared", erase_mask, 0);

    // R6 R10 R11 R12 random sector erase with suspend
    for (int i = 0; i < 10; i++) begin
      int s = int'($urandom_range(0, NS - 1));
      logic [NS-1:0] em = NS'(1) << s;
      erase_seq(sect_addr(s, int'($urandom)), 8'h30);
      chk(erase_start == 1 && mode == 3, "R6 start", mode, 3);
      chk(erase_mask == em, "R6 mask", erase_mask, em);
      wr(AW'($urandom), 8'hB0);
      chk(mode == 4, "R10 suspend", mode, 4);
      for (int j = 0; j < 6; j++) begin
        logic [AW-1:0] ra = (j == 0) ? sect_addr(s, int'($urandom)) : AW'($urandom);
        @(negedge clk); rd_addr = ra; #1;
        chk(rd_status_sel == exp_sel(em, ra), "R11 suspend read",
            rd_status_sel, exp_sel(em, ra));
      end
      wr(12'h555, 8'hF0);
      chk(mode == 4, "R10 reset ignored in suspend", mode, 4);
      unlock(); wr(12'h555, 8'hA0); wr(AW'($urandom), 8'h77);
      chk(prog_start == 1 && mode == 5, "R12 suspend program", mode, 5);
      done_pulse(1'b0);
      chk(mode == 4 && erase_mask == em, "R12 back to suspend", mode, 4);
      wr(AW'($urandom), 8'h30);
      chk(mode == 3, "R10 resume", mode, 3);
      done_pulse(1'b0);
      chk(mode == 0 && erase_mask == 0, "R7 sector done", mode, 0);
    end

    // R8 failure paths
    unlock(); wr(12'h555, 8'hA0); wr(12'h040, 8'h33);
    done_pulse(1'b1);
    chk(mode == 6, "R8 prog fail", mode, 6);
    chk(rd_status_sel == 1, "R11 error status", rd_status_sel, 1);
    unlock(); wr(12'h555, 8'h90);
    chk(mode == 6, "R8 ignore", mode, 6);
    wr(AW'($urandom), 8'hF0);
    chk(mode == 0, "R8 exit", mode, 0);
    erase_seq(sect_addr(5, 7), 8'h30);
    done_pulse(1'b1);
    chk(mode == 6 && erase_mask == 8'h20, "R8 erase fail", erase_mask, 8'h20);
    wr(12'h000, 8'hF0);
    chk(mode == 0 && erase_mask == 0, "R8 reset clears", erase_mask, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule